// File: doc/BRIEF.md
# Fan Tachometer Period Monitor

This block times the pulse train from a fan tachometer in cycles of the system clock. It then judges each result against an expected interval that software loads, widened by a symmetric tolerance. Software uses the two event pulses to learn of each fresh result and of any result outside the allowed window. A typical use is to load the expected interval from a measurement taken at a known-good duty, with a quarter of that value as the tolerance. Because a fan produces one, two or four pulses per revolution, one result always covers a single pulse interval, not a full turn. Converting that interval to a rotation speed is left to software.

The raw tach line passes through a synchroniser, and an interval is timed from one rising edge to the next. If no edge arrives before the interval counter reaches its top value, the result is reported at that top value and counted as a fault. The window check is suspended in two cases: for a programmable number of cycles after each duty change, while the fan settles, and for as long as the duty is zero. Results are pushed out as single-cycle events with no back-pressure. The reported interval stays on the output until the next result, so a consumer that cannot accept an event simply reads the held value later.

Top module: `fan_tach_monitor`

## Requirements
- R1: While reset is held and after it is released, `period_o` reads 0 (no valid measurement), and `new_meas_o` and `tach_err_o` are low until the first measurement completes.
- R2: `tach_i` is sampled through `SYNC_STAGES` flip-flops and timed on its rising edges. The first rising edge after reset, or after a timeout, only starts an interval and produces no event.
- R3: A completed interval is reported on `period_o` as the number of clock cycles between two consecutive rising edges. The value is held until the next event.
- R4: Each completed interval or timeout raises `new_meas_o` for exactly one cycle, and it is never raised twice in a row.
- R5: The accepted window is [`exp_period_i` − `tol_i`, `exp_period_i` + `tol_i`], both ends inclusive. The lower end saturates at 0 and the upper end saturates at 2^`CNT_W`−1.
- R6: When checking is enabled, `tach_err_o` pulses in the same cycle as `new_meas_o` for a result outside the window, and stays low for a result inside it.
- R7: If the counter reaches 2^`CNT_W`−1 without a rising edge, a result of 2^`CNT_W`−1 is reported and counted as outside the window. The next edge then re-arms timing.
- R8: A one-cycle `duty_chg_i` pulse loads a settle timer with `SETTLE_CYCLES`. While the timer is non-zero, `tach_err_o` stays low.
- R9: While `duty_zero_i` is high, `tach_err_o` stays low.
- R10: `tach_err_o` is never high unless `new_meas_o` is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every interval is counted in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| tach_i | input | 1 | Raw, asynchronous tachometer line |
| exp_period_i | input | CNT_W | Expected interval in clock cycles |
| tol_i | input | CNT_W | Allowed deviation either side of the expected interval |
| duty_chg_i | input | 1 | One-cycle pulse when the fan duty is changed |
| duty_zero_i | input | 1 | High while the fan duty is 0% |
| period_o | output | CNT_W | Most recent interval result; 0 until the first one |
| new_meas_o | output | 1 | One-cycle pulse for each new result |
| tach_err_o | output | 1 | One-cycle pulse when a checked result lies outside the window |

## Verification
The hardest conditions to reach from the ports are a result that lands just inside, and then just outside, the settle period after a duty change, and a counter that saturates. For the first, the stimulus pulses the duty-change input and follows it at once with a train of short, badly off-target intervals. The earlier results fall while the timer is still running and the later ones fall after it expires, so the scoreboard expects suppressed errors first and real errors afterwards. For saturation, the bench is built with a narrow counter and the tach line is held low beyond its range. The bench also places an edge exactly at the counter's top value, which checks that a real edge at saturation counts as a measurement rather than a timeout.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;
  // Interval counter states.
  typedef enum logic {
    TS_WAIT_EDGE = 1'b0,  // no open interval; next rising edge arms timing
    TS_TIMING    = 1'b1   // interval open, counting cycles
  } tach_state_e;
endpackage

// File: rtl/tach_edge_sync.sv
module tach_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tach_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], tach_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;

  // R2: a synchronised rising edge lasts exactly one cycle
  p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tach_period_ctr.sv
module tach_period_ctr
  import fan_tach_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  output logic             meas_stb_o,
  output logic [CNT_W-1:0] meas_val_o,
  output logic             timeout_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  tach_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             at_top;

  assign at_top = (cnt_q == CNT_MAX);

  always_comb begin
    meas_stb_o = 1'b0;
    timeout_o  = 1'b0;
    meas_val_o = cnt_q;
    if (state_q == TS_TIMING) begin
      if (rise_i) begin
        meas_stb_o = 1'b1;
      end else if (at_top) begin
        meas_stb_o = 1'b1;
        timeout_o  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TS_WAIT_EDGE;
      cnt_q   <= '0;
    end else if (rise_i) begin
      state_q <= TS_TIMING;
      cnt_q   <= CNT_ONE;
    end else if (state_q == TS_TIMING) begin
      if (at_top) state_q <= TS_WAIT_EDGE;
      else        cnt_q   <= cnt_q + CNT_ONE;
    end
  end

  // R7: saturation without an edge closes the interval
  p_sat_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TS_TIMING && at_top && !rise_i) |=> (state_q == TS_WAIT_EDGE));
  // R2: with no open interval the counter does not move until an edge
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TS_WAIT_EDGE && !rise_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tach_window_chk.sv
module tach_window_chk #(
  parameter int CNT_W         = 16,
  parameter int SETTLE_CYCLES = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             meas_stb_i,
  input  logic [CNT_W-1:0] meas_val_i,
  input  logic             timeout_i,
  input  logic [CNT_W-1:0] exp_period_i,
  input  logic [CNT_W-1:0] tol_i,
  input  logic             duty_chg_i,
  input  logic             duty_zero_i,
  output logic [CNT_W-1:0] period_o,
  output logic             new_meas_o,
  output logic             tach_err_o
);
  localparam int               SET_W    = $clog2(SETTLE_CYCLES + 1);
  localparam logic [SET_W-1:0] SET_LOAD = SET_W'(SETTLE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [SET_W-1:0] settle_q;
  logic [CNT_W:0]   hi_sum;
  logic [CNT_W-1:0] win_lo, win_hi;
  logic             outside, check_on, settle_busy;

  // Window edges, each saturating at the counter range
  assign hi_sum  = {1'b0, exp_period_i} + {1'b0, tol_i};
  assign win_hi  = hi_sum[CNT_W] ? CNT_MAX : hi_sum[CNT_W-1:0];
  assign win_lo  = (tol_i > exp_period_i) ? '0 : (exp_period_i - tol_i);
  assign outside = timeout_i || (meas_val_i < win_lo) || (meas_val_i > win_hi);

  assign settle_busy = (settle_q != '0);
  assign check_on    = !settle_busy && !duty_zero_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      settle_q <= '0;
    end else if (duty_chg_i) begin
      settle_q <= SET_LOAD;
    end else if (settle_busy) begin
      settle_q <= settle_q - SET_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_o   <= '0;
      new_meas_o <= 1'b0;
      tach_err_o <= 1'b0;
    end else begin
      new_meas_o <= meas_stb_i;
      tach_err_o <= meas_stb_i && outside && check_on;
      if (meas_stb_i) period_o <= meas_val_i;
    end
  end

  // R8: no fault report while the settle timer runs
  p_settle_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    settle_busy |=> !tach_err_o);
  // R9: no fault report while the duty is zero
  p_zero_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    duty_zero_i |=> !tach_err_o);
  // R6: a result within the window never raises a fault
  p_inside_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_stb_i && !timeout_i && meas_val_i >= win_lo && meas_val_i <= win_hi) |=> !tach_err_o);
endmodule

// File: rtl/fan_tach_monitor.sv
module fan_tach_monitor #(
  parameter int CNT_W         = 16,
  parameter int SYNC_STAGES   = 2,
  parameter int SETTLE_CYCLES = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tach_i,
  input  logic [CNT_W-1:0] exp_period_i,
  input  logic [CNT_W-1:0] tol_i,
  input  logic             duty_chg_i,
  input  logic             duty_zero_i,
  output logic [CNT_W-1:0] period_o,
  output logic             new_meas_o,
  output logic             tach_err_o
);
  logic             rise;
  logic             meas_stb;
  logic             timeout;
  logic [CNT_W-1:0] meas_val;

  tach_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .tach_i (tach_i),
    .rise_o (rise)
  );

  tach_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_i     (rise),
    .meas_stb_o (meas_stb),
    .meas_val_o (meas_val),
    .timeout_o  (timeout)
  );

  tach_window_chk #(.CNT_W(CNT_W), .SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .meas_stb_i   (meas_stb),
    .meas_val_i   (meas_val),
    .timeout_i    (timeout),
    .exp_period_i (exp_period_i),
    .tol_i        (tol_i),
    .duty_chg_i   (duty_chg_i),
    .duty_zero_i  (duty_zero_i),
    .period_o     (period_o),
    .new_meas_o   (new_meas_o),
    .tach_err_o   (tach_err_o)
  );

  // R10: a fault only accompanies a result
  p_err_with_meas_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tach_err_o |-> new_meas_o);
  // R4: result events are single-cycle
  p_meas_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    new_meas_o |=> !new_meas_o);
  // R3: the reported interval only changes together with an event
  p_period_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !new_meas_o |-> $stable(period_o));
endmodule

// File: tb/fan_tach_monitor_tb.sv
module fan_tach_monitor_tb;
  localparam int CNT_W  = 12;
  localparam int SETTLE = 200;
  localparam int MAXV   = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tach = 1'b0;
  logic [CNT_W-1:0] exp_p = '0;
  logic [CNT_W-1:0] tol = '0;
  logic             duty_chg = 1'b0;
  logic             duty_zero = 1'b0;
  logic [CNT_W-1:0] period;
  logic             new_meas;
  logic             tach_err;

  always #10 clk = ~clk;  // 50 MHz

  fan_tach_monitor #(.CNT_W(CNT_W), .SYNC_STAGES(2), .SETTLE_CYCLES(SETTLE)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .tach_i       (tach),
    .exp_period_i (exp_p),
    .tol_i        (tol),
    .duty_chg_i   (duty_chg),
    .duty_zero_i  (duty_zero),
    .period_o     (period),
    .new_meas_o   (new_meas),
    .tach_err_o   (tach_err)
  );

  int    checks = 0;
  int    fails  = 0;
  int    events = 0;
  int    q_per[$];
  bit    q_err[$];
  int    prev_p = 0;
  bit    prev_ok = 1'b0;
  string scen = "R1";
  bit    done = 1'b0;

  function automatic bit win_err(int p);
    int lo, hi;
    lo = (int'(tol) > int'(exp_p)) ? 0 : int'(exp_p) - int'(tol);
    hi = int'(exp_p) + int'(tol);
    if (hi > MAXV) hi = MAXV;
    return (p < lo) || (p > hi);
  endfunction

  task automatic check(string req, int act, int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  // Driver: a rising edge now; interval p cycles to the next call.
  // The interval that this edge closes is queued with its expected fault.
  task automatic edge_iv(int p, bit gate);
    if (prev_ok) begin
      q_per.push_back(prev_p);
      q_err.push_back(win_err(prev_p) & gate);
    end
    prev_p  = p;
    prev_ok = 1'b1;
    tach = 1'b1;
    repeat (p / 2) @(negedge clk);
    tach = 1'b0;
    repeat (p - p / 2) @(negedge clk);
  endtask

  // Hold the line low until the counter saturates (R7).
  task automatic stall(bit gate);
    if (prev_ok) begin
      q_per.push_back(MAXV);
      q_err.push_back(gate);
    end
    prev_ok = 1'b0;
    tach = 1'b0;
    repeat (MAXV + 20) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (tach_err && !new_meas) begin
        checks++; fails++;
        $display("FAIL R10: actual err=1 meas=0 expected err=0");
      end
      if (new_meas) begin
        events++;
        if (q_per.size() == 0) begin
          checks++; fails++;
          $display("FAIL R4 (%s): actual unexpected result %0d expected none", scen, period);
        end else begin
          check({"R3 ", scen}, int'(period), q_per.pop_front());
          check({"R6 ", scen}, int'(tach_err), int'(q_err.pop_front()));
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 period in reset", int'(period), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 period after reset", int'(period), 0);
    check("R1 meas after reset", int'(new_meas), 0);
    check("R1 err after reset", int'(tach_err), 0);

    exp_p = 12'(1000); tol = 12'(250);
    // R2: first edge only arms
    scen = "R2";
    edge_iv(1000, 1'b1);
    check("R2 no event after first edge", events, 0);
    // R5: window edges, inclusive
    scen = "R5";
    edge_iv(900, 1'b1);
    edge_iv(750, 1'b1);
    edge_iv(749, 1'b1);
    edge_iv(1250, 1'b1);
    edge_iv(1251, 1'b1);
    edge_iv(400, 1'b1);
    scen = "R7";
    stall(1'b1);
    // R2: after timeout the first edge re-arms only
    scen = "R2";
    edge_iv(300, 1'b1);
    // R5: tolerance above expected -> lower end at 0
    scen = "R5 low sat";
    exp_p = 12'(100); tol = 12'(200);
    edge_iv(20, 1'b1);
    edge_iv(300, 1'b1);
    edge_iv(301, 1'b1);
    edge_iv(50, 1'b1);
    stall(1'b1);
    // R5: upper end saturates; edge exactly at top value is a measurement
    scen = "R5 high sat";
    exp_p = 12'(4000); tol = 12'(200);
    edge_iv(4000, 1'b1);
    edge_iv(4095, 1'b1);
    edge_iv(3799, 1'b1);
    edge_iv(100, 1'b1);
    stall(1'b1);
    // R9: zero duty suppresses faults, including timeout
    scen = "R9";
    exp_p = 12'(1000); tol = 12'(250);
    duty_zero = 1'b1;
    edge_iv(300, 1'b0);
    edge_iv(300, 1'b0);
    edge_iv(300, 1'b0);
    stall(1'b0);
    duty_zero = 1'b0;
    // R8: settle timer suppresses faults, then expires
    scen = "R8";
    duty_chg = 1'b1;
    @(negedge clk);
    duty_chg = 1'b0;
    edge_iv(60, 1'b0);
    edge_iv(60, 1'b0);
    edge_iv(60, 1'b0);
    edge_iv(60, 1'b0);
    edge_iv(60, 1'b1);
    edge_iv(60, 1'b1);
    stall(1'b1);

    repeat (10) @(negedge clk);
    check("R4 all results delivered", q_per.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule